// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache

This block is a direct-mapped data cache that sits between a word-oriented CPU port and a slower backing memory. Each line stores a valid flag, a tag and a block of 2^LOG2_BLOCK 32-bit words. A read that hits returns the addressed word in the same cycle. A read that misses stalls the CPU. The whole block is then fetched word by word, and the access restarts and hits.

Writes always go through to memory. A write that hits updates the line and memory in the same cycle. A write that misses first refills the block, then restarts as a write hit. Cache capacity (2^LOG2_WORDS words) and block width are parameters. LOG2_BLOCK must be at least 1 and smaller than LOG2_WORDS.

The CPU holds `cpu_req`, `cpu_we`, `cpu_addr` and `cpu_wdata` steady while `cpu_stall` is high. An access completes at the rising edge in which `cpu_req` is high and `cpu_stall` is low. A memory transfer happens at a rising edge in which both `mem_req` and `mem_ready` are high. For reads, `mem_rdata` must be valid in that same cycle.

Top module: `dm_wt_cache`

## Requirements
- R1: The byte address is split as follows. Bits [1:0] are ignored. Bits [LOG2_BLOCK+1:2] select the word in the block. Bits [LOG2_WORDS+1:LOG2_BLOCK+2] select the line. Bits [31:LOG2_WORDS+2] form the tag. Two addresses that differ only in bits [1:0] return the same word.
- R2: After reset every line is invalid. No memory request is pending, and an idle CPU port is not stalled. The first access to any line misses.
- R3: A read whose line is valid and whose stored tag matches returns the word in the same cycle without a stall. It issues no memory transfer.
- R4: On a miss, `cpu_stall` is high from the cycle the miss is seen until the restarted access completes. With `mem_ready` held high this is exactly 1 + 2^LOG2_BLOCK cycles.
- R5: A refill issues exactly 2^LOG2_BLOCK memory reads, never writes. They start at the block-aligned address, step up by one word per accepted transfer, and wait while `mem_ready` is low.
- R6: A write hit issues exactly one memory write carrying the word-aligned address and the CPU data. The line is updated in the cycle memory accepts that write, and the CPU stalls until then.
- R7: A write miss refills the block from memory first, then performs the write as in R6. Later reads return the new word, and the block's other words come from memory.
- R8: Two addresses with the same line index and different tags evict each other. After one is filled, the other misses and refills.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | CPU access request, held while stalled |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | CPU byte address |
| cpu_wdata | input | 32 | CPU write data |
| cpu_rdata | output | 32 | Read data for the addressed word |
| cpu_stall | output | 1 | CPU must hold its request |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 32 | Word-aligned memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_ready |
| mem_ready | input | 1 | Memory accepts the current transfer |

## Verification
A write hit updates the line and writes memory in one cycle, and both must happen in the cycle `mem_ready` is high. This is provoked by write hits and write misses while `mem_ready` pulses only every fourth cycle. The check is judged three ways. The CPU must stay stalled until the pulse. Exactly one memory write with the right address and data must be logged. A following read must return the new word. Likewise, the last refill beat fills the line and validates the tag at the same edge that restarts the access, which is judged by a zero-wait hit on the next word.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
    localparam int unsigned WORD_W   = 32;
    localparam int unsigned ADDR_W   = 32;
    localparam int unsigned BYTE_OFS = 2;

    typedef enum logic {
        ST_LOOKUP = 1'b0,
        ST_REFILL = 1'b1
    } dmc_state_e;

    typedef struct packed {
        logic              req;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] data;
    } mem_cmd_t;

    function automatic logic [ADDR_W-1:0] word_align(input logic [ADDR_W-1:0] a);
        return {a[ADDR_W-1:BYTE_OFS], {BYTE_OFS{1'b0}}};
    endfunction
endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
    parameter int unsigned IDX_W = 4,
    parameter int unsigned TAG_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    input  logic             upd_en,
    output logic             hit
);
    localparam int unsigned LINES = 1 << IDX_W;

    logic [LINES-1:0] valid_q;
    logic [TAG_W-1:0] tag_q [LINES];

    always_ff @(posedge clk) begin
        if (rst)
            valid_q <= '0;
        else if (upd_en)
            valid_q[lk_idx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (upd_en)
            tag_q[lk_idx] <= lk_tag;
    end

    assign hit = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);

    // R2: nothing hits in the first cycle after reset
    p_reset_invalid_r2: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !hit);
endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
    parameter int unsigned IDX_W  = 4,
    parameter int unsigned WOFS_W = 2
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WOFS_W-1:0] rd_woff,
    output logic [31:0]       rd_data,
    input  logic              wr_en,
    input  logic [WOFS_W-1:0] wr_woff,
    input  logic [31:0]       wr_data
);
    localparam int unsigned ENTRIES = 1 << (IDX_W + WOFS_W);

    logic [31:0] words_q [ENTRIES];

    always_ff @(posedge clk) begin
        if (wr_en)
            words_q[{idx, wr_woff}] <= wr_data;
    end

    assign rd_data = words_q[{idx, rd_woff}];
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
    import dmc_pkg::*;
#(
    parameter int unsigned WOFS_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic              hit,
    input  logic              mem_ready,
    output logic              cpu_stall,
    output logic              refill,
    output logic              refill_last,
    output logic [WOFS_W-1:0] beat,
    output logic              mem_req,
    output logic              mem_we
);
    localparam logic [WOFS_W-1:0] LAST_BEAT = '1;

    dmc_state_e        state_q;
    logic [WOFS_W-1:0] beat_q;
    logic              wt_go;

    always_comb begin
        refill      = (state_q == ST_REFILL);
        refill_last = refill && mem_ready && (beat_q == LAST_BEAT);
        wt_go       = !refill && cpu_req && cpu_we && hit;
        mem_req     = refill || wt_go;
        mem_we      = wt_go;
        cpu_stall   = cpu_req && (refill || !hit || (cpu_we && !mem_ready));
        beat        = beat_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_LOOKUP;
            beat_q  <= '0;
        end else begin
            case (state_q)
                ST_LOOKUP: begin
                    if (cpu_req && !hit) begin
                        state_q <= ST_REFILL;
                        beat_q  <= '0;
                    end
                end
                default: begin
                    if (mem_ready) begin
                        beat_q <= beat_q + 1'b1;
                        if (beat_q == LAST_BEAT)
                            state_q <= ST_LOOKUP;
                    end
                end
            endcase
        end
    end

    // R4: a detected miss starts a refill at beat zero
    p_miss_starts_refill_r4: assert property (@(posedge clk) disable iff (rst)
        (!refill && cpu_req && !hit) |=> (refill && beat_q == '0));

    // R5: each accepted beat advances the word counter by one
    p_beat_step_r5: assert property (@(posedge clk) disable iff (rst)
        (refill && mem_ready && !refill_last) |=> (refill && beat_q == $past(beat_q) + 1'b1));

    // R5: a stalled beat holds its position
    p_beat_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (refill && !mem_ready) |=> (refill && $stable(beat_q)));
endmodule

// File: rtl/dm_wt_cache.sv
module dm_wt_cache
    import dmc_pkg::*;
#(
    parameter int unsigned LOG2_WORDS = 6,
    parameter int unsigned LOG2_BLOCK = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cpu_req,
    input  logic        cpu_we,
    input  logic [31:0] cpu_addr,
    input  logic [31:0] cpu_wdata,
    output logic [31:0] cpu_rdata,
    output logic        cpu_stall,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata,
    input  logic        mem_ready
);
    localparam int unsigned IDX_W  = LOG2_WORDS - LOG2_BLOCK;
    localparam int unsigned TAG_W  = 30 - LOG2_WORDS;
    localparam int unsigned IDX_LO = BYTE_OFS + LOG2_BLOCK;
    localparam int unsigned TAG_LO = BYTE_OFS + LOG2_WORDS;

    logic [LOG2_BLOCK-1:0] woff, beat;
    logic [IDX_W-1:0]      idx;
    logic [TAG_W-1:0]      tag;
    logic                  hit, refill, refill_last, ds_we;
    logic                  c_req, c_we;
    mem_cmd_t              cmd;

    assign woff = cpu_addr[IDX_LO-1:BYTE_OFS];
    assign idx  = cpu_addr[TAG_LO-1:IDX_LO];
    assign tag  = cpu_addr[ADDR_W-1:TAG_LO];

    dmc_ctrl #(.WOFS_W(LOG2_BLOCK)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .cpu_req     (cpu_req),
        .cpu_we      (cpu_we),
        .hit         (hit),
        .mem_ready   (mem_ready),
        .cpu_stall   (cpu_stall),
        .refill      (refill),
        .refill_last (refill_last),
        .beat        (beat),
        .mem_req     (c_req),
        .mem_we      (c_we)
    );

    dmc_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk    (clk),
        .rst    (rst),
        .lk_idx (idx),
        .lk_tag (tag),
        .upd_en (refill_last),
        .hit    (hit)
    );

    assign ds_we = mem_ready && (refill || c_we);

    dmc_data_store #(.IDX_W(IDX_W), .WOFS_W(LOG2_BLOCK)) u_data (
        .clk     (clk),
        .idx     (idx),
        .rd_woff (woff),
        .rd_data (cpu_rdata),
        .wr_en   (ds_we),
        .wr_woff (refill ? beat : woff),
        .wr_data (refill ? mem_rdata : cpu_wdata)
    );

    always_comb begin
        cmd.req  = c_req;
        cmd.we   = c_we;
        cmd.addr = refill ? {tag, idx, beat, {BYTE_OFS{1'b0}}} : word_align(cpu_addr);
        cmd.data = cpu_wdata;
    end

    assign mem_req   = cmd.req;
    assign mem_we    = cmd.we;
    assign mem_addr  = cmd.addr;
    assign mem_wdata = cmd.data;

    // R5: after the final beat, the held address hits
    p_refill_then_hit_r5: assert property (@(posedge clk) disable iff (rst)
        refill_last |=> (!$stable(cpu_addr) || hit));

    // R6: a completed write went to memory with its address and data
    p_write_through_r6: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && cpu_we && !cpu_stall) |->
            (mem_req && mem_we && mem_ready &&
             mem_addr[31:2] == cpu_addr[31:2] && mem_wdata == cpu_wdata));

    // R6: a finished write is visible to a following read of the same word
    p_write_visible_r6: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && cpu_we && !cpu_stall) |=>
            (cpu_addr != $past(cpu_addr) || cpu_rdata == $past(cpu_wdata)));
endmodule

// File: tb/sim_dm_wt_cache.sv
module sim_dm_wt_cache;
    localparam int CLK_PERIOD = 10;
    localparam int LW  = 6;
    localparam int LB  = 2;
    localparam int WPB = 1 << LB;
    localparam int IW  = LW - LB;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic [31:0] cpu_rdata, mem_addr, mem_wdata, mem_rdata;
    logic        cpu_stall, mem_req, mem_we, mem_ready;
    logic        throttle = 1'b0;
    logic [1:0]  ph = '0;

    int errors = 0;
    int checks = 0;

    logic [31:0] mem_store [logic [31:0]];
    logic [31:0] ref_store [logic [31:0]];
    logic [31:0] rd_log [$];
    logic [31:0] wr_log_a [$];
    logic [31:0] wr_log_d [$];
    logic [31:0] exp_data_q [$];
    string       exp_req_q [$];
    logic        mv [1 << IW];
    logic [31:0] mt [1 << IW];

    always #(CLK_PERIOD / 2) clk = ~clk;

    dm_wt_cache #(.LOG2_WORDS(LW), .LOG2_BLOCK(LB)) u0 (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_stall(cpu_stall), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready)
    );

    function automatic logic [31:0] pat(input logic [31:0] a);
        return {a[15:0] ^ 16'h5A3C, ~a[15:0]};
    endfunction

    function automatic logic [31:0] mem_read(input logic [31:0] a);
        if (mem_store.exists(a)) return mem_store[a];
        return pat(a);
    endfunction

    function automatic logic [31:0] ref_read(input logic [31:0] a);
        if (ref_store.exists(a)) return ref_store[a];
        return pat(a);
    endfunction

    assign mem_rdata = mem_read(mem_addr);
    assign mem_ready = !throttle || (ph == 2'd0);

    always @(posedge clk) begin
        ph <= ph + 2'd1;
        if (!rst && mem_req && mem_ready) begin
            if (mem_we) begin
                mem_store[mem_addr] = mem_wdata;
                wr_log_a.push_back(mem_addr);
                wr_log_d.push_back(mem_wdata);
            end else begin
                rd_log.push_back(mem_addr);
            end
        end
    end

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // scoreboard monitor: pops an expected word for every completed read
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (!rst && cpu_req && !cpu_we && !cpu_stall) begin
                if (exp_data_q.size() == 0) begin
                    chk(1'b0, "R3 unexpected read", cpu_rdata, 32'h0);
                end else begin
                    logic [31:0] e;
                    string rq;
                    e  = exp_data_q.pop_front();
                    rq = exp_req_q.pop_front();
                    chk(cpu_rdata == e, rq, cpu_rdata, e);
                end
            end
        end
    end

    task automatic access(input logic we, input logic [31:0] a, input logic [31:0] wd, input string rq);
        int stalls = 0;
        int exp_st;
        logic [IW-1:0] ix;
        logic [31:0] tg, base, wa;
        bit miss;
        ix   = a[LB+2+IW-1:LB+2];
        tg   = a >> (LW + 2);
        wa   = {a[31:2], 2'b00};
        base = (a >> (LB + 2)) << (LB + 2);
        miss = !(mv[ix] && mt[ix] == tg);
        exp_st = throttle ? -1 : (miss ? 1 + WPB : 0);
        rd_log.delete();
        wr_log_a.delete();
        wr_log_d.delete();
        if (!we) begin
            exp_data_q.push_back(ref_read(wa));
            exp_req_q.push_back({rq, " read data"});
        end
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        forever begin
            #1;
            if (!cpu_stall) break;
            stalls++;
            @(negedge clk);
        end
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0;
        mv[ix] = 1'b1;
        mt[ix] = tg;
        if (we) ref_store[wa] = wd;
        if (exp_st >= 0)
            chk(stalls == exp_st, {rq, " stall cycles"}, stalls, exp_st);
        if (miss) begin
            chk(rd_log.size() == WPB, {rq, " R5 refill count"}, rd_log.size(), WPB);
            foreach (rd_log[k])
                chk(rd_log[k] == base + 32'(4 * k), {rq, " R5 refill address"}, rd_log[k], base + 32'(4 * k));
        end else begin
            chk(rd_log.size() == 0, {rq, " R3 no refill on hit"}, rd_log.size(), 0);
        end
        if (we) begin
            chk(wr_log_a.size() == 1, {rq, " R6 one memory write"}, wr_log_a.size(), 1);
            if (wr_log_a.size() == 1) begin
                chk(wr_log_a[0] == wa, {rq, " R6 write address"}, wr_log_a[0], wa);
                chk(wr_log_d[0] == wd, {rq, " R6 write data"}, wr_log_d[0], wd);
            end
        end else begin
            chk(wr_log_a.size() == 0, {rq, " no write on read"}, wr_log_a.size(), 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < (1 << IW); i++) begin
            mv[i] = 1'b0;
            mt[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(cpu_stall == 1'b0, "R2 idle stall after reset", cpu_stall, 0);
        chk(mem_req == 1'b0, "R2 no memory request after reset", mem_req, 0);

        access(1'b0, 32'h0000_0100, '0, "R2 R4 first read miss");
        access(1'b0, 32'h0000_0104, '0, "R3 hit word1");
        access(1'b0, 32'h0000_0108, '0, "R3 hit word2");
        access(1'b0, 32'h0000_010C, '0, "R3 hit word3");
        access(1'b0, 32'h0000_0109, '0, "R1 byte offset ignored");
        access(1'b0, 32'h0000_0103, '0, "R1 byte offset word0");
        access(1'b1, 32'h0000_0104, 32'hDEAD_0104, "R6 write hit");
        access(1'b0, 32'h0000_0104, '0, "R6 read after write");
        access(1'b1, 32'h0000_0220, 32'hBEEF_0220, "R7 write miss");
        access(1'b0, 32'h0000_0224, '0, "R7 neighbour from memory");
        access(1'b0, 32'h0000_0220, '0, "R7 written word");
        access(1'b0, 32'h0000_1100, '0, "R8 conflict fill");
        access(1'b0, 32'h0000_0104, '0, "R8 evicted line misses");
        access(1'b0, 32'h0000_1104, '0, "R8 other tag evicted");

        throttle = 1'b1;
        access(1'b0, 32'h0000_3010, '0, "R5 throttled refill");
        access(1'b1, 32'h0000_3018, 32'h1234_5678, "R6 throttled write hit");
        access(1'b0, 32'h0000_3018, '0, "R6 throttled readback");
        access(1'b1, 32'h0000_5030, 32'hCAFE_5030, "R7 throttled write miss");
        access(1'b0, 32'h0000_5034, '0, "R7 throttled neighbour");
        access(1'b0, 32'h0000_5030, '0, "R7 throttled written word");
        throttle = 1'b0;

        for (int i = 0; i < (1 << IW); i++)
            access(1'b0, 32'h0000_4000 + 32'(i * 4 * WPB), '0, "R8 sweep fill");
        for (int i = 0; i < (1 << IW); i++)
            access(1'b0, 32'h0000_4004 + 32'(i * 4 * WPB), '0, "R3 sweep hit");

        repeat (2) @(negedge clk);
        chk(exp_data_q.size() == 0, "R3 all reads observed", exp_data_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule